// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches a group of external interrupt pins and turns qualified transitions on them into sticky request flags for an interrupt controller. Two vectored pins each follow a software-chosen polarity. A third vectored pin reacts to any change of level. One quasi pin reacts to rising transitions only. Four key-scan pins share one quasi flag that any of them sets on a falling transition. Quasi flags are for polling only and never raise a vectored request.

Every pin passes through a majority-free noise filter. The filter only adopts a new level after three consecutive clock samples agree. The first selectable pin also passes through a two-stage synchroniser ahead of its filter. The second selectable pin is filtered straight from the pad, so it responds two cycles sooner. Software clears flags with a per-flag clear strobe. A new qualified transition in the same cycle as its clear leaves the flag set. The vectored flags are gated with an enable mask to form the request outputs.

The control pins are level signals with no handshake. There is no data stream, so no valid/ready interface and no back-pressure apply.

Top module: `eint_edge_unit`

## Requirements
- R1: While `rst_n` is low, `flag_q` and `irq_req` are all zero, regardless of pin activity.
- R2: A pin level is accepted only after three consecutive clock samples of the same value. A pulse that lasts two clocks raises no flag. A pulse that lasts three clocks is accepted.
- R3: For `pin_b`, `pin_c`, `pin_d` and `pin_key`, a qualifying change driven before clock edge 1 sets its flag at edge 4. For `pin_a` the flag is set at edge 6, because of the two synchroniser stages.
- R4: `edge_sel_a` and `edge_sel_b` choose the polarity: 0 means rising and 1 means falling. The opposite transition sets no flag.
- R5: Both rising and falling transitions of `pin_d` set `flag_q[2]`.
- R6: A rising transition of `pin_c` sets `flag_q[3]`. A falling transition of `pin_c` sets nothing.
- R7: A falling transition on any bit of `pin_key` sets the shared flag `flag_q[4]`. Rising transitions set nothing.
- R8: A set flag stays set until its `flag_clr` bit is high at a clock edge. That edge clears only the flags whose clear bits are set.
- R9: When a qualified transition and the clear bit for the same flag meet at one clock edge, the flag remains set.
- R10: `irq_req[i] = flag_q[i] & irq_en[i]` for i = 0..2, where bit 0 is pin_a, bit 1 is pin_b and bit 2 is pin_d. The quasi flags `flag_q[3]` (pin_c) and `flag_q[4]` (keys) never reach `irq_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Selectable-edge vectored pin, synchronised |
| pin_b | input | 1 | Selectable-edge vectored pin, not synchronised |
| pin_c | input | 1 | Rising-edge quasi pin |
| pin_d | input | 1 | Both-edge vectored pin |
| pin_key | input | NKEY | Falling-edge key-scan pins, one shared flag |
| edge_sel_a | input | 1 | Polarity for pin_a (0 rising, 1 falling) |
| edge_sel_b | input | 1 | Polarity for pin_b (0 rising, 1 falling) |
| irq_en | input | 3 | Enable mask for vectored flags {d, b, a} |
| flag_clr | input | 5 | Per-flag clear strobe {key, c, d, b, a} |
| flag_q | output | 5 | Request flags {key, c, d, b, a} |
| irq_req | output | 3 | Enabled vectored requests {d, b, a} |

## Verification
The hardest situation to reach from the pins is the collision of a clear strobe with a freshly accepted transition. The acceptance edge sits a fixed number of clocks after the pin change, set by the sample window. The stimulus first leaves the flag set. It then drives the pin at a falling clock edge, counts three rising edges, and raises the clear bit just before the fourth. The same clear bit alone, one cycle later, must then empty the flag. The pulse-width boundary of the filter is handled the same way, with pulses held for exactly two clocks and for exactly three.

// File: rtl/eint_pkg.sv
package eint_pkg;
  // flag vector layout
  localparam int SRC_A = 0;
  localparam int SRC_B = 1;
  localparam int SRC_D = 2;
  localparam int SRC_C = 3;
  localparam int SRC_K = 4;
  localparam int NSRC  = 5;
  localparam int NVEC  = 3;  // low bits that may produce vectored requests

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
      assign q_o = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/eint_filter.sv
module eint_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [LEN-1:0] smp;
  logic           all_hi;
  logic           all_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[LEN-2:0], d_i};
  end

  assign all_hi = &smp;
  assign all_lo = ~|smp;

  // transition pulses are valid in the cycle the new level is adopted
  assign rise_o = all_hi & ~lvl_o;
  assign fall_o = all_lo &  lvl_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_o <= 1'b0;
    else if (all_hi) lvl_o <= 1'b1;
    else if (all_lo) lvl_o <= 1'b0;
  end
endmodule

// File: rtl/eint_req_flag.sv
module eint_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set wins over clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/eint_edge_unit.sv
module eint_edge_unit
  import eint_pkg::*;
#(
  parameter int NKEY        = 4,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_a,
  input  logic            pin_b,
  input  logic            pin_c,
  input  logic            pin_d,
  input  logic [NKEY-1:0] pin_key,
  input  logic            edge_sel_a,
  input  logic            edge_sel_b,
  input  logic [NVEC-1:0] irq_en,
  input  logic [NSRC-1:0] flag_clr,
  output logic [NSRC-1:0] flag_q,
  output logic [NVEC-1:0] irq_req
);
  logic            a_sync;
  logic            a_lvl, a_rise, a_fall;
  logic            b_lvl, b_rise, b_fall;
  logic            c_lvl, c_rise, c_fall;
  logic            d_lvl, d_rise, d_fall;
  logic [NKEY-1:0] k_lvl, k_rise, k_fall;
  logic [NSRC-1:0] evt;

  // only pin_a crosses a synchroniser; pin_b feeds its filter directly
  eint_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .d_i(pin_a), .q_o(a_sync)
  );

  eint_filter #(.LEN(FILT_LEN)) u_filt_a (
    .clk(clk), .rst_n(rst_n), .d_i(a_sync),
    .lvl_o(a_lvl), .rise_o(a_rise), .fall_o(a_fall)
  );
  eint_filter #(.LEN(FILT_LEN)) u_filt_b (
    .clk(clk), .rst_n(rst_n), .d_i(pin_b),
    .lvl_o(b_lvl), .rise_o(b_rise), .fall_o(b_fall)
  );
  eint_filter #(.LEN(FILT_LEN)) u_filt_c (
    .clk(clk), .rst_n(rst_n), .d_i(pin_c),
    .lvl_o(c_lvl), .rise_o(c_rise), .fall_o(c_fall)
  );
  eint_filter #(.LEN(FILT_LEN)) u_filt_d (
    .clk(clk), .rst_n(rst_n), .d_i(pin_d),
    .lvl_o(d_lvl), .rise_o(d_rise), .fall_o(d_fall)
  );

  generate
    for (genvar k = 0; k < NKEY; k++) begin : g_key
      eint_filter #(.LEN(FILT_LEN)) u_filt_k (
        .clk(clk), .rst_n(rst_n), .d_i(pin_key[k]),
        .lvl_o(k_lvl[k]), .rise_o(k_rise[k]), .fall_o(k_fall[k])
      );
    end
  endgenerate

  // per-source event qualification
  always_comb begin
    evt        = '0;
    evt[SRC_A] = (edge_pol_e'(edge_sel_a) == EDGE_FALL) ? a_fall : a_rise;
    evt[SRC_B] = (edge_pol_e'(edge_sel_b) == EDGE_FALL) ? b_fall : b_rise;
    evt[SRC_D] = d_rise | d_fall;
    evt[SRC_C] = c_rise;
    evt[SRC_K] = |k_fall;
  end

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_flag
      eint_req_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .set_i(evt[s]), .clr_i(flag_clr[s]), .q_o(flag_q[s])
      );
    end
  endgenerate

  assign irq_req = flag_q[NVEC-1:0] & irq_en;

  // levels and unused polarities are kept for observability only
  logic unused_ok;
  assign unused_ok = ^{a_lvl, b_lvl, c_lvl, d_lvl, k_lvl, c_fall, k_rise};
endmodule

// File: rtl/eint_edge_unit_chk.sv
module eint_edge_unit_chk
  import eint_pkg::*;
#(
  parameter int NKEY = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pin_c,
  input logic            pin_d,
  input logic [NKEY-1:0] pin_key,
  input logic [NVEC-1:0] irq_en,
  input logic [NSRC-1:0] flag_clr,
  input logic [NSRC-1:0] flag_q,
  input logic [NVEC-1:0] irq_req
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (flag_q == '0));

  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~flag_clr) != '0) |=>
      ((flag_q & $past(flag_q & ~flag_clr)) == $past(flag_q & ~flag_clr)));

  // R10
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~irq_en) == '0));

  // R6 R2
  a_r6_c_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_C]) |->
      ($past(pin_c, 2) && $past(pin_c, 3) && $past(pin_c, 4)));

  // R5 R2
  a_r5_d_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_D]) |->
      (($past(pin_d, 2) == $past(pin_d, 3)) && ($past(pin_d, 3) == $past(pin_d, 4))));

  // R7
  a_r7_key_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_K]) |-> !(&$past(pin_key, 2)));
endmodule

bind eint_edge_unit eint_edge_unit_chk #(.NKEY(NKEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_c(pin_c), .pin_d(pin_d), .pin_key(pin_key),
  .irq_en(irq_en), .flag_clr(flag_clr), .flag_q(flag_q), .irq_req(irq_req)
);

// File: tb/tb_eint_edge_unit.sv
module tb_eint_edge_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0, pin_d = 1'b0;
  logic [3:0] pin_key = 4'h0;
  logic       edge_sel_a = 1'b0, edge_sel_b = 1'b0;
  logic [2:0] irq_en = 3'b000;
  logic [4:0] flag_clr = 5'b0;
  logic [4:0] flag_q;
  logic [2:0] irq_req;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  eint_edge_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
    .pin_d(pin_d), .pin_key(pin_key), .edge_sel_a(edge_sel_a),
    .edge_sel_b(edge_sel_b), .irq_en(irq_en), .flag_clr(flag_clr),
    .flag_q(flag_q), .irq_req(irq_req)
  );

  // {pin_a, pin_b, pin_c, pin_d, pin_key[3:0]} , expected {key, c, d, b, a}
  localparam logic [12:0] VEC [11] = '{
    {8'b1000_0000, 5'b00001},
    {8'b1100_0000, 5'b00010},
    {8'b1110_0000, 5'b01000},
    {8'b1111_0000, 5'b00100},
    {8'b1111_1111, 5'b00000},
    {8'b1111_0111, 5'b10000},
    {8'b0001_0111, 5'b00000},
    {8'b0000_0111, 5'b00100},
    {8'b0000_0000, 5'b10000},
    {8'b1111_1111, 5'b01111},
    {8'b0000_0000, 5'b10100}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_all();
    @(negedge clk) flag_clr = 5'b11111;
    @(negedge clk) flag_clr = 5'b00000;
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk(flag_q, 5'b0, "R1 flags in reset");
    chk(irq_req, 3'b0, "R1 requests in reset");
    @(negedge clk) rst_n = 1'b1;

    // table walk: R5 R6 R7 R4 with rising selection
    for (int i = 0; i < 11; i++) begin
      @(negedge clk) {pin_a, pin_b, pin_c, pin_d, pin_key} = VEC[i][12:5];
      repeat (8) @(posedge clk);
      #1 chk(flag_q, VEC[i][4:0], $sformatf("R5 R6 R7 R4 table row %0d", i));
      clr_all();
    end

    // R3 latency, unsynchronised pin
    @(negedge clk) pin_b = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk(flag_q[1], 1'b0, "R3 pin_b before edge 4");
    @(posedge clk); #1 chk(flag_q[1], 1'b1, "R3 pin_b at edge 4");
    // R3 latency, synchronised pin
    @(negedge clk) pin_a = 1'b1;
    repeat (5) @(posedge clk);
    #1 chk(flag_q[0], 1'b0, "R3 pin_a before edge 6");
    @(posedge clk); #1 chk(flag_q[0], 1'b1, "R3 pin_a at edge 6");

    // R10 masking
    #1 chk(irq_req, 3'b000, "R10 all masked");
    @(negedge clk) irq_en = 3'b001;
    #1 chk(irq_req, 3'b001, "R10 only a enabled");
    @(negedge clk) irq_en = 3'b111;
    #1 chk(irq_req, 3'b011, "R10 a and b enabled");

    // R8 sticky and selective clear
    repeat (20) @(posedge clk);
    #1 chk(flag_q, 5'b00011, "R8 flags hold");
    @(negedge clk) flag_clr = 5'b00001;
    @(posedge clk); #1 chk(flag_q, 5'b00010, "R8 clear only a");
    @(negedge clk) flag_clr = 5'b0;

    // R2 filter boundary on pin_c
    @(negedge clk) pin_c = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) pin_c = 1'b0;
    settle(); chk(flag_q[3], 1'b0, "R2 two-clock pulse rejected");
    @(negedge clk) pin_c = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) pin_c = 1'b0;
    settle(); chk(flag_q[3], 1'b1, "R2 three-clock pulse accepted");
    chk(irq_req, 3'b010, "R10 quasi c gives no request");

    // R9 set beats clear, then R8 plain clear
    clr_all();
    @(negedge clk) pin_c = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) flag_clr = 5'b01000;
    @(posedge clk); #1 chk(flag_q[3], 1'b1, "R9 set wins over clear");
    @(negedge clk) flag_clr = 5'b01000;
    @(posedge clk); #1 chk(flag_q[3], 1'b0, "R8 clear without edge");
    @(negedge clk) flag_clr = 5'b0;

    // R6 falling c ignored
    @(negedge clk) pin_c = 1'b0;
    settle(); chk(flag_q[3], 1'b0, "R6 falling c ignored");

    // R4 falling selection
    clr_all();
    @(negedge clk) begin edge_sel_a = 1'b1; edge_sel_b = 1'b1; pin_a = 1'b0; pin_b = 1'b0; end
    settle(); chk(flag_q[1:0], 2'b11, "R4 falling accepted");
    clr_all();
    @(negedge clk) begin pin_a = 1'b1; pin_b = 1'b1; end
    settle(); chk(flag_q[1:0], 2'b00, "R4 rising ignored when falling chosen");

    // R1 reset in the middle of activity
    @(negedge clk) pin_d = 1'b1;
    settle(); chk(flag_q[2], 1'b1, "R5 d rise before reset");
    @(negedge clk) rst_n = 1'b0;
    #1 chk(flag_q, 5'b0, "R1 asynchronous clear");
    chk(irq_req, 3'b0, "R1 requests dropped");
    @(negedge clk) rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule